// File: doc/BRIEF.md
# Path Metric Normalizer

The block keeps the accumulated state metrics of a Viterbi decoder from drifting out of range. Every accepted step carries a vector of signed 16-bit state metrics and a per-step enable flag. A pipelined tree of pairwise comparisons finds the smallest metric. When the step's enable flag is set, that minimum is subtracted from every metric with saturation to the signed 16-bit range. When the flag is clear, the vector passes through untouched. Each adjusted metric goes back to the lane it came from.

The caller decides on which steps to normalize, usually by watching the growth of the metrics, and raises the enable flag on those steps. One vector can be accepted every cycle. Each tree level is registered, and a valid bit and the step's enable flag travel with the data. The minimum found is always reported on a side output, whether or not that step was normalized. The state count is 16 by default and set by a parameter; 64 is the other intended value. It must be a power of two.

Top module: `pmn_top`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and metrics_o and min_o are all zeros.
- R2: A step presented with valid_i high appears on valid_o exactly log2(NUM_STATES)+1 cycles later (5 cycles for 16 states). Steps may be presented back to back every cycle, and each produces exactly one output in the same order.
- R3: min_o equals the smallest lane of the step's input vector, with lanes compared as two's-complement signed values.
- R4: With norm_en_i high, each output lane equals the input lane minus the minimum. The result is clamped to the range -32768 to 32767, so a difference above 32767 reads 32767.
- R5: With norm_en_i low, metrics_o equals the step's input vector bit for bit.
- R6: Lane k of the vector occupies bits [k*16 +: 16] on both metrics_i and metrics_o. Each result stays in the lane of its source.
- R7: On a normalized step, no output lane is negative and at least one output lane is zero.
- R8: The enable flag belongs to its own step. Consecutive steps with different flags are each treated according to their own flag.
- R9: min_o carries the minimum on steps where norm_en_i is low as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Step present on the inputs |
| norm_en_i | input | 1 | Subtract the minimum on this step |
| metrics_i | input | NUM_STATES*16 | State metrics, lane k at bits [k*16 +: 16] |
| valid_o | output | 1 | Result present on the outputs |
| metrics_o | output | NUM_STATES*16 | Adjusted or passed-through metrics |
| min_o | output | 16 | Signed minimum of the step's input vector |

## Verification
Saturation and the zero floor can both apply to one vector. This happens when the minimum is -32768 and another lane sits near 32767: that lane must clamp at 32767 while the minimum lane reads exactly zero. Directed vectors set up this case, with the extreme lanes placed at the first and last positions and in between. The random stimulus also draws full-range lanes, which reach the clamp on many steps. The bench judges each result against a reference computed from the input, in which the difference is clipped. It also checks that the smallest output lane of every normalized step is zero and that no output lane is negative. Back-to-back steps with alternating flags test that each step is handled by its own flag.

// File: rtl/pmn_pkg.sv
package pmn_pkg;
  // clamp an integer into the signed range of w bits (w <= 31)
  function automatic int sat_clip(int v, int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/pmn_min_stage.sv
module pmn_min_stage #(
  parameter int unsigned W     = 16,
  parameter int unsigned VEC_N = 16,
  parameter int unsigned N_IN  = 16,
  parameter int unsigned PAY_W = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [VEC_N*W-1:0] vals_i,
  input  logic [PAY_W-1:0]   pay_i,
  output logic               valid_o,
  output logic [VEC_N*W-1:0] vals_o,
  output logic [PAY_W-1:0]   pay_o
);
  localparam int unsigned H = N_IN / 2;

  logic [VEC_N*W-1:0] nxt;

  for (genvar j = 0; j < H; j++) begin : g_cmp
    logic signed [W-1:0] lo_v, hi_v;
    assign lo_v = vals_i[j*W +: W];
    assign hi_v = vals_i[(j+H)*W +: W];
    assign nxt[j*W +: W] = (hi_v < lo_v) ? hi_v : lo_v;
  end
  assign nxt[VEC_N*W-1:H*W] = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vals_o  <= '0;
      pay_o   <= '0;
    end else begin
      valid_o <= valid_i;
      vals_o  <= nxt;
      pay_o   <= pay_i;
    end
  end

  for (genvar j = 0; j < H; j++) begin : g_chk
    p_tree_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ($signed(vals_o[j*W +: W]) <= $signed($past(vals_i[j*W +: W])))
               && ($signed(vals_o[j*W +: W]) <= $signed($past(vals_i[(j+H)*W +: W]))));
  end
endmodule

// File: rtl/pmn_norm_out.sv
module pmn_norm_out #(
  parameter int unsigned W      = 16,
  parameter int unsigned STATES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                en_i,
  input  logic [W-1:0]        min_i,
  input  logic [STATES*W-1:0] metrics_i,
  output logic                valid_o,
  output logic [STATES*W-1:0] metrics_o,
  output logic [W-1:0]        min_o
);
  logic [STATES*W-1:0] nxt;
  logic [STATES-1:0]   hit, zero_l, neg_l;
  logic                en_q;

  for (genvar k = 0; k < STATES; k++) begin : g_lane
    logic signed [W-1:0] lane_in, mn;
    logic [W-1:0]        lane_out;
    int                  diff;
    assign lane_in  = metrics_i[k*W +: W];
    assign mn       = min_i;
    assign diff     = pmn_pkg::sat_clip(int'(lane_in) - int'(mn), W);
    assign nxt[k*W +: W] = en_i ? W'(diff) : lane_in;
    assign hit[k]   = (lane_in == mn);
    assign lane_out = metrics_o[k*W +: W];
    assign zero_l[k] = (lane_out == '0);
    assign neg_l[k]  = lane_out[W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      en_q      <= 1'b0;
      metrics_o <= '0;
      min_o     <= '0;
    end else begin
      valid_o   <= valid_i;
      en_q      <= en_i;
      metrics_o <= nxt;
      min_o     <= min_i;
    end
  end

  p_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && en_q) |-> ((|zero_l) && !(|neg_l)));
  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !en_q) |-> (metrics_o == $past(metrics_i)));
  p_min_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(|hit));
endmodule

// File: rtl/pmn_top.sv
module pmn_top #(
  parameter int unsigned NUM_STATES = 16,
  parameter int unsigned METRIC_W   = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  logic                           norm_en_i,
  input  logic [NUM_STATES*METRIC_W-1:0] metrics_i,
  output logic                           valid_o,
  output logic [NUM_STATES*METRIC_W-1:0] metrics_o,
  output logic [METRIC_W-1:0]            min_o
);
  localparam int unsigned LVLS  = $clog2(NUM_STATES);
  localparam int unsigned VW    = NUM_STATES * METRIC_W;
  localparam int unsigned PAY_W = VW + 1;

  logic [VW-1:0]    vals_l [LVLS+1];
  logic [PAY_W-1:0] pay_l  [LVLS+1];
  logic             vld_l  [LVLS+1];

  assign vals_l[0] = metrics_i;
  assign pay_l[0]  = {norm_en_i, metrics_i};
  assign vld_l[0]  = valid_i;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    pmn_min_stage #(
      .W(METRIC_W), .VEC_N(NUM_STATES), .N_IN(NUM_STATES >> l), .PAY_W(PAY_W)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(vld_l[l]),
      .vals_i (vals_l[l]),
      .pay_i  (pay_l[l]),
      .valid_o(vld_l[l+1]),
      .vals_o (vals_l[l+1]),
      .pay_o  (pay_l[l+1])
    );
  end

  pmn_norm_out #(.W(METRIC_W), .STATES(NUM_STATES)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (vld_l[LVLS]),
    .en_i     (pay_l[LVLS][VW]),
    .min_i    (vals_l[LVLS][METRIC_W-1:0]),
    .metrics_i(pay_l[LVLS][VW-1:0]),
    .valid_o  (valid_o),
    .metrics_o(metrics_o),
    .min_o    (min_o)
  );
endmodule

// File: tb/tb_pmn_top.sv
module tb_pmn_top;
  localparam int NS  = 16;
  localparam int W   = 16;
  localparam int LAT = 5;

  typedef struct {
    logic [NS*W-1:0] m;
    logic [W-1:0]    mn;
    logic            en;
    int              cyc;
    string           tag;
  } exp_t;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic            norm_en_i = 1'b0;
  logic [NS*W-1:0] metrics_i = '0;
  logic            valid_o;
  logic [NS*W-1:0] metrics_o;
  logic [W-1:0]    min_o;

  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  int   outs = 0;
  int   ins = 0;
  bit   done = 0;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  pmn_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .norm_en_i(norm_en_i),
    .metrics_i(metrics_i), .valid_o(valid_o), .metrics_o(metrics_o), .min_o(min_o)
  );

  function automatic logic [W-1:0] ref_min(logic [NS*W-1:0] v);
    int m = 32767;
    for (int k = 0; k < NS; k++)
      if (int'($signed(v[k*W +: W])) < m) m = int'($signed(v[k*W +: W]));
    return W'(m);
  endfunction

  function automatic logic [NS*W-1:0] ref_out(logic [NS*W-1:0] v, logic en);
    logic [NS*W-1:0] r;
    int mn = int'($signed(ref_min(v)));
    for (int k = 0; k < NS; k++) begin
      int d = int'($signed(v[k*W +: W])) - mn;
      if (d > 32767) d = 32767;
      r[k*W +: W] = en ? W'(d) : v[k*W +: W];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [NS*W-1:0] act, logic [NS*W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_out();
    if (!valid_o) return;
    outs++;
    if (q.size() == 0) begin
      chk(0, "R2", "unexpected valid_o", 1, 0);
      return;
    end
    begin
      exp_t e = q.pop_front();
      bit has_zero = 0;
      bit has_neg = 0;
      chk(cyc - e.cyc == LAT, "R2", "latency", cyc - e.cyc, LAT);
      chk(min_o == e.mn, e.en ? {e.tag, "/R3"} : {e.tag, "/R3/R9"}, "min_o", min_o, e.mn);
      chk(metrics_o == ref_out(e.m, e.en), e.en ? {e.tag, "/R4/R6"} : {e.tag, "/R5/R6"},
          "metrics_o", metrics_o, ref_out(e.m, e.en));
      if (e.en) begin
        for (int k = 0; k < NS; k++) begin
          if (metrics_o[k*W +: W] == '0) has_zero = 1;
          if (metrics_o[k*W + W - 1]) has_neg = 1;
        end
        chk(has_zero && !has_neg, "R7", "zero floor", {has_zero, has_neg}, 2'b10);
      end
    end
  endtask

  task automatic step(logic v, logic en, logic [NS*W-1:0] vec, string tag);
    exp_t e;
    @(negedge clk_i);
    check_out();
    valid_i   = v;
    norm_en_i = en;
    metrics_i = vec;
    if (v) begin
      e.m = vec; e.mn = ref_min(vec); e.en = en; e.cyc = cyc; e.tag = tag;
      q.push_back(e);
      ins++;
    end
    cyc++;
  endtask

  function automatic logic [NS*W-1:0] fill(int val);
    logic [NS*W-1:0] r;
    for (int k = 0; k < NS; k++) r[k*W +: W] = W'(val);
    return r;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    logic [NS*W-1:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    chk(valid_o == 0 && metrics_o == '0 && min_o == '0, "R1", "reset state",
        {valid_o, min_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed corners
    step(1, 1, fill(100), "DIR_equal");
    v = fill(5); v[0 +: W] = 16'h8000; v[(NS-1)*W +: W] = 16'h7FFF;
    step(1, 1, v, "DIR_sat_edges");
    v = fill(32767); v[7*W +: W] = 16'h8000;
    step(1, 1, v, "DIR_sat_mid");
    step(1, 0, v, "DIR_pass_sat");
    v = '0;
    for (int k = 0; k < NS; k++) v[k*W +: W] = W'(1000 - 37 * k);
    step(1, 1, v, "DIR_lane_order");
    step(1, 0, v, "DIR_lane_pass");
    step(1, 1, fill(-32768), "DIR_all_min");
    step(0, 1, fill(7), "DIR_idle");
    for (int i = 0; i < 8; i++) begin
      v = fill(-200 + i);
      v[(i*2)*W +: W] = W'(-300 - i);
      step(1, i[0], v, "R8_alt");
    end

    for (int i = 0; i < 400; i++) begin
      logic vv = ($urandom % 5) != 0;
      logic en = $urandom % 2;
      int   mode = $urandom % 3;
      for (int k = 0; k < NS; k++) begin
        int x;
        if (mode == 0) x = int'($urandom % 65536) - 32768;
        else if (mode == 1) x = int'($urandom % 16) - 8;
        else x = 30000 + int'($urandom % 2768);
        v[k*W +: W] = W'(x);
      end
      if (mode == 2 && ($urandom % 2)) v[($urandom % NS)*W +: W] = 16'h8000;
      step(vv, en, v, "RND");
    end
    for (int i = 0; i < LAT + 3; i++) step(0, 0, '0, "DRAIN");
    chk(q.size() == 0 && outs == ins, "R2", "output count", outs, ins);
    done = 1;
    finish_run();
  end
endmodule